// File: doc/BRIEF.md
# Programmable Edge-Triggered Sample Pulse Generator

This block turns an external sample-timing signal, which runs with no fixed phase relation to the master clock, into a clean internal sampling strobe. The input first passes through a synchronizer. When detection is switched on, one edge direction is chosen as the trigger, and a strobe exactly one master-clock period wide follows every such edge after a programmable wait of 0 to 7 master-clock periods. If a second trigger arrives while an earlier wait is still running, both strobes are issued.

When detection is off, the synchronized input drives the strobe output directly, and the polarity and delay settings have no effect. A bypass output always carries the synchronized input, for logic that needs the raw timing.

The configuration inputs are registered every clock. A synchronous software-reset input clears the configuration, the synchronizer and every pending strobe in a single clock.

Top module: `samp_pulse_gen`

## Requirements
- R1: With detection disabled, `smp_pulse` equals the synchronized input and follows a change on `smp_in` two clocks later, whatever `edge_pol` and `dly_cfg` hold.
- R2: With detection enabled and `edge_pol`=0, a falling edge (1 to 0) on `smp_in` produces a strobe, and a rising edge produces none.
- R3: With detection enabled and `edge_pol`=1, a rising edge (0 to 1) on `smp_in` produces a strobe, and a falling edge produces none.
- R4: If a trigger change on `smp_in` is first sampled at clock edge k and `dly_cfg` is d, `smp_pulse` is high from clock edge k+2+d. That is d+1 clocks after the cycle in which the synchronized edge is seen.
- R5: Each strobe generated in detection mode is high for exactly one clock.
- R6: A trigger that arrives while an earlier delay is still counting does not cancel it. Each trigger yields its own strobe at its own scheduled time.
- R7: After `rst_n` is released, `smp_pulse` and `smp_byp` are 0 and detection is off (detect-enable 0, polarity 0, delay 0).
- R8: A clock with `soft_rst`=1 clears the configuration, the synchronizer and all pending strobes. `smp_pulse` and `smp_byp` are 0 in the next cycle, and a pending strobe is never issued.
- R9: `smp_byp` always equals `smp_in` delayed through the two-flop synchronizer: a change is visible two clocks after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| smp_in | input | 1 | External sample-timing signal, asynchronous |
| det_en | input | 1 | 1 = edge detection and delay active |
| edge_pol | input | 1 | Trigger edge: 0 falling, 1 rising |
| dly_cfg | input | 3 | Strobe delay in master-clock periods |
| smp_pulse | output | 1 | Internal sampling strobe |
| smp_byp | output | 1 | Synchronized external input |

## Verification
The strobe-width property assumes that `dly_cfg` is not changed while a strobe is pending. Otherwise two triggers two clocks apart could be scheduled into adjacent slots and merge into a two-clock strobe. The polarity property assumes that the synchronizer output comes only from `smp_in` between resets. The stimulus therefore changes configuration only after the input has settled for several idle clocks. It drives `smp_in` and the configuration on the falling clock edge, and it spaces trigger edges at least two clocks apart, so every check reads settled values.

// File: rtl/spg_pkg.sv
package spg_pkg;
  // Trigger qualifier: cur/prev are successive synchronized samples.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Clock edge (after first sampling) at which the strobe is first high.
  function automatic int strobe_lag(input int dly, input int sync_stages);
    return sync_stages + dly;
  endfunction
endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain[g] <= 1'b0;
        else if (clr) chain[g] <= 1'b0;
        else          chain[g] <= (g == 0) ? din : chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spg_edge.sv
module spg_edge
  import spg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic rising,
  input  logic sig,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= 1'b0;
    else if (clr) prev_q <= 1'b0;
    else          prev_q <= sig;
  end

  assign hit = en & edge_hit(sig, prev_q, rising);
endmodule

// File: rtl/spg_sched.sv
module spg_sched #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             hit,
  input  logic [DLY_W-1:0] dly,
  output logic             due
);
  localparam int SLOTS = 1 << DLY_W;

  logic [SLOTS-1:0] slots_q;
  logic [SLOTS-1:0] insert;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign insert[g] = hit && (dly == DLY_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slots_q <= '0;
    else if (clr || !en)  slots_q <= '0;
    else                  slots_q <= (slots_q >> 1) | insert;
  end

  assign due = slots_q[0];
endmodule

// File: rtl/samp_pulse_gen.sv
module samp_pulse_gen #(
  parameter int DLY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             smp_in,
  input  logic             det_en,
  input  logic             edge_pol,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             smp_pulse,
  output logic             smp_byp
);
  logic             det_q;
  logic             pol_q;
  logic [DLY_W-1:0] dly_q;
  logic             sync_w;
  logic             edge_w;
  logic             due_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      pol_q <= 1'b0;
      dly_q <= '0;
    end else if (soft_rst) begin
      det_q <= 1'b0;
      pol_q <= 1'b0;
      dly_q <= '0;
    end else begin
      det_q <= det_en;
      pol_q <= edge_pol;
      dly_q <= dly_cfg;
    end
  end

  spg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .din(smp_in), .dout(sync_w)
  );

  spg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .en(det_q),
    .rising(pol_q), .sig(sync_w), .hit(edge_w)
  );

  spg_sched #(.DLY_W(DLY_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .en(det_q),
    .hit(edge_w), .dly(dly_q), .due(due_w)
  );

  assign smp_pulse = det_q ? due_w : sync_w;
  assign smp_byp   = sync_w;
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             det_en,
  input logic             det_q,
  input logic             pol_q,
  input logic [DLY_W-1:0] dly_q,
  input logic             edge_w,
  input logic             smp_pulse,
  input logic             smp_byp
);
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_q |-> (smp_pulse == smp_byp));

  // R2
  fall_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && !pol_q) |-> (!smp_byp && $past(smp_byp)));

  // R3
  rise_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && pol_q) |-> (smp_byp && !$past(smp_byp)));

  // R4
  zero_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && dly_q == '0 && det_en && !soft_rst) |=> smp_pulse);

  // R5
  one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q && smp_pulse && det_en && !soft_rst) |=> !smp_pulse);

  // R8
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!smp_pulse && !smp_byp && !det_q));
endmodule

bind samp_pulse_gen spg_checker #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .det_en(det_en),
  .det_q(det_q), .pol_q(pol_q), .dly_q(dly_q), .edge_w(edge_w),
  .smp_pulse(smp_pulse), .smp_byp(smp_byp)
);

// File: tb/tb_samp_pulse_gen.sv
module tb_samp_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       smp_in = 1'b0;
  logic       det_en = 1'b0;
  logic       edge_pol = 1'b0;
  logic [2:0] dly_cfg = 3'd0;
  logic       smp_pulse;
  logic       smp_byp;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  samp_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .smp_in(smp_in),
    .det_en(det_en), .edge_pol(edge_pol), .dly_cfg(dly_cfg),
    .smp_pulse(smp_pulse), .smp_byp(smp_byp)
  );

  // vector: {pol, dly}
  localparam logic [3:0] VEC [8] = '{
    4'b1_000, 4'b0_001, 4'b1_010, 4'b0_011,
    4'b1_100, 4'b0_101, 4'b1_110, 4'b0_111
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Configure with detection off, settle input level, then enable.
  task automatic arm(input logic pol, input logic [2:0] d, input logic lvl);
    det_en = 1'b0; edge_pol = pol; dly_cfg = d; smp_in = lvl;
    idle(5);
    det_en = 1'b1;
    idle(3);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    // R7: reset state
    check("R7 pulse", smp_pulse, 1'b0);
    check("R7 byp", smp_byp, 1'b0);
    rst_n = 1'b1;
    idle(2);
    check("R7 pulse after release", smp_pulse, 1'b0);
    check("R7 byp after release", smp_byp, 1'b0);

    // Table walk: trigger edge -> strobe at k+2+d (R2, R3, R4, R5),
    // opposite edge -> no strobe.
    for (int v = 0; v < 8; v++) begin
      automatic logic       pol = VEC[v][3];
      automatic int         d   = int'(VEC[v][2:0]);
      arm(pol, VEC[v][2:0], ~pol);
      smp_in = pol;
      for (int n = 1; n <= d + 5; n++) begin
        @(negedge clk);
        check(pol ? "R3/R4/R5 trigger" : "R2/R4/R5 trigger", smp_pulse, n == d + 3);
      end
      smp_in = ~pol;
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk);
        check(pol ? "R3 other edge" : "R2 other edge", smp_pulse, 1'b0);
      end
    end

    // R1 / R9: detection off, settings ignored, two-clock passthrough
    det_en = 1'b0; edge_pol = 1'b1; dly_cfg = 3'd5; smp_in = 1'b0;
    idle(4);
    for (int t = 0; t < 4; t++) begin
      automatic logic lvl = ~smp_in;
      edge_pol = t[0]; dly_cfg = 3'(t * 2 + 1);
      smp_in = lvl;
      @(negedge clk);
      check("R1 not yet", smp_pulse, ~lvl);
      check("R9 not yet", smp_byp, ~lvl);
      @(negedge clk);
      check("R1 follows", smp_pulse, lvl);
      check("R9 follows", smp_byp, lvl);
      idle(2);
    end

    // R6: two rising triggers two clocks apart, delay 4
    arm(1'b1, 3'd4, 1'b0);
    smp_in = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n == 1) smp_in = 1'b0;
      if (n == 2) smp_in = 1'b1;
      check("R6 queued", smp_pulse, (n == 7) || (n == 9));
    end

    // R8: soft reset while a delay-7 falling trigger is pending
    arm(1'b0, 3'd7, 1'b1);
    smp_in = 1'b0;
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      soft_rst = (n == 4);
      check("R8 pending dropped", smp_pulse, 1'b0);
      if (n == 5) check("R8 byp cleared", smp_byp, 1'b0);
    end

    summary();
  end
endmodule